// File: doc/BRIEF.md
# Octal Flash Power-Up Mode Sequencer

After reset, an octal NOR flash accepts commands on one data line only, at single transfer rate. This block brings the device into octal double-data-rate operation. When it is started, it drives a single-line SPI master port and sends a fixed series of commands. The series sets the read latency in dummy clocks, then switches the device to 32-bit addressing, then switches it to octal DDR mode.

Each configuration write has the same three parts:
- a write-enable command;
- a series of status reads that ends when the write-enable latch is seen as set;
- the volatile register write itself.

If the latch does not appear within a programmable number of status reads, the block abandons the series and raises an error. If the series completes, a one-cycle completion pulse is raised. The mode-change write is always the last single-line traffic the block produces.

The block is control only. It has no streaming data interface, so it has no valid/ready handshake. Start, busy, done and error are plain level or pulse pins. The dummy-cycle value and the poll limit are captured when a start is accepted.

Top module: `octflash_modeswitch_seq`

## Requirements
- R1: Out of reset, and whenever the block is idle, chip select is high (inactive), the serial clock is low, and busy, done and error are low. The serial clock is low whenever chip select is high.
- R2: Each command uses SPI mode 0. Bits are sent MSB first and change only while the serial clock is low. MISO is sampled on the rising edge of the serial clock.
- R3: Each register write is preceded by two things, each in its own chip-select frame. First, the write-enable opcode 0x06 (8 bits alone). Then one or more status reads, each made of opcode 0x05 followed by 8 bits read back. The write follows the first status read whose byte has bit 1 set; all other bits of that byte are ignored.
- R4: The register writes use opcode 0x81 and come in this order:
  - register 0x01 with a 24-bit address, data = the captured dummy-cycle value;
  - register 0x05 with a 24-bit address, data 0xFE;
  - register 0x00 with a 32-bit address, data 0xE7.
  Each frame is opcode, then address, then one data byte, with no dummy clocks.
- R5: After a status read that fails, chip select stays high for at least POLL_GAP (16) clocks before the next status read starts.
- R6: If max_polls_i consecutive status reads all show the latch clear, the block sends no further frames. It then returns to idle with error high and done never raised. A max_polls_i of 0 behaves like 1.
- R7: After the chip-select frame of the final (mode 0xE7) write ends, done is high for exactly one clock, with chip select high and busy low.
- R8: A start that arrives while busy is ignored: the frame series and the done count are the same as for a single start.
- R9: The dummy-cycle value is captured when start is accepted. Later changes to dummy_cycles_i do not affect the running series.
- R10: Every command occupies its own chip-select frame. Chip select goes high between commands.
- R11: error stays high until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled when idle |
| dummy_cycles_i | input | 8 | Read dummy-cycle count to program |
| max_polls_i | input | POLL_CNT_W | Status reads allowed per write |
| miso_i | input | 1 | Serial data from the flash |
| cs_n_o | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data to the flash |
| busy_o | output | 1 | Series in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Poll limit exhausted, held until next start |

## Verification
A flash model in the bench decodes every chip-select frame. It holds the write-enable latch off for a chosen number of status reads after each write enable. That delay and the poll limit are swept over a full grid, so one case just succeeds and the neighbouring case just aborts. This separates an off-by-one in the poll limit from errors in the ordering of the series.

The status bytes returned when the latch is clear have every bit except bit 1 set. The bytes returned when it is set are 0x02 or 0xFF. This shows that only the latch bit decides the outcome.

A second start, together with a change of the dummy value in the middle of a run, shows that the block ignores both. Frame spacing is measured to confirm the pause between polls.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

  localparam int FRAME_W = 48;
  localparam int CNT_W   = 6;

  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam logic [7:0] OPC_WRVR  = 8'h81;
  localparam logic [7:0] WEL_MASK  = 8'h02;
  localparam logic [7:0] WEL_MATCH = 8'h02;

  localparam logic [7:0] REG_LAT   = 8'h01;
  localparam logic [7:0] REG_AMODE = 8'h05;
  localparam logic [7:0] REG_IOMOD = 8'h00;
  localparam logic [7:0] VAL_A32   = 8'hFE;
  localparam logic [7:0] VAL_OCDDR = 8'hE7;

  localparam logic [1:0] LAST_STEP = 2'd2;
  localparam logic [1:0] WIDE_FROM = 2'd2;

  typedef enum logic [1:0] {K_WREN, K_POLL, K_WRITE} cmd_kind_e;
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_GAP} seq_state_e;
  typedef enum logic [2:0] {E_IDLE, E_LO, E_HI, E_TAIL, E_GAP} eng_state_e;

  function automatic logic [7:0] step_reg(input logic [1:0] idx);
    case (idx)
      2'd0:    return REG_LAT;
      2'd1:    return REG_AMODE;
      default: return REG_IOMOD;
    endcase
  endfunction

  function automatic logic [7:0] step_data(input logic [1:0] idx, input logic [7:0] lat);
    case (idx)
      2'd0:    return lat;
      2'd1:    return VAL_A32;
      default: return VAL_OCDDR;
    endcase
  endfunction

endpackage

// File: rtl/fsq_frame_build.sv
module fsq_frame_build
  import fsq_pkg::*;
(
  input  cmd_kind_e            kind_i,
  input  logic [1:0]           step_i,
  input  logic [7:0]           lat_i,
  output logic [FRAME_W-1:0]   tx_word_o,
  output logic [CNT_W-1:0]     tx_bits_o,
  output logic [CNT_W-1:0]     rx_bits_o
);

  logic [7:0] reg_sel;
  logic [7:0] reg_val;

  assign reg_sel = step_reg(step_i);
  assign reg_val = step_data(step_i, lat_i);

  always_comb begin
    tx_word_o = '0;
    tx_bits_o = CNT_W'(8);
    rx_bits_o = '0;
    case (kind_i)
      K_WREN: begin
        tx_word_o[FRAME_W-1 -: 8] = OPC_WREN;
      end
      K_POLL: begin
        tx_word_o[FRAME_W-1 -: 8] = OPC_RDSR;
        rx_bits_o = CNT_W'(8);
      end
      default: begin
        if (step_i >= WIDE_FROM) begin
          tx_word_o = {OPC_WRVR, 24'h000000, reg_sel, reg_val};
          tx_bits_o = CNT_W'(48);
        end else begin
          tx_word_o = {OPC_WRVR, 16'h0000, reg_sel, reg_val, 8'h00};
          tx_bits_o = CNT_W'(40);
        end
      end
    endcase
  end

endmodule

// File: rtl/fsq_spi_engine.sv
module fsq_spi_engine
  import fsq_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go_i,
  input  logic [FRAME_W-1:0] tx_word_i,
  input  logic [CNT_W-1:0]   tx_bits_i,
  input  logic [CNT_W-1:0]   rx_bits_i,
  input  logic               miso_i,
  output logic               cs_n_o,
  output logic               sck_o,
  output logic               mosi_o,
  output logic [7:0]         rx_byte_o,
  output logic               fin_o
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  eng_state_e          st_q;
  logic [DIV_W-1:0]    div_q;
  logic [CNT_W-1:0]    left_q;
  logic [FRAME_W-1:0]  sh_q;
  logic [7:0]          rx_q;
  logic                cs_q, sck_q, fin_q;
  logic                half_end;

  assign half_end  = (div_q == DIV_LAST);
  assign cs_n_o    = cs_q;
  assign sck_o     = sck_q;
  assign mosi_o    = sh_q[FRAME_W-1];
  assign rx_byte_o = rx_q;
  assign fin_o     = fin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= E_IDLE;
      div_q  <= '0;
      left_q <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      cs_q   <= 1'b1;
      sck_q  <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      case (st_q)
        E_IDLE: begin
          if (go_i) begin
            sh_q   <= tx_word_i;
            left_q <= CNT_W'(tx_bits_i + rx_bits_i);
            cs_q   <= 1'b0;
            div_q  <= '0;
            st_q   <= E_LO;
          end
        end
        E_LO: begin
          if (half_end) begin
            div_q <= '0;
            sck_q <= 1'b1;
            rx_q  <= {rx_q[6:0], miso_i};
            st_q  <= E_HI;
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        E_HI: begin
          if (half_end) begin
            div_q  <= '0;
            sck_q  <= 1'b0;
            sh_q   <= {sh_q[FRAME_W-2:0], 1'b0};
            left_q <= left_q - 1'b1;
            st_q   <= (left_q == CNT_W'(1)) ? E_TAIL : E_LO;
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        E_TAIL: begin
          if (half_end) begin
            div_q <= '0;
            cs_q  <= 1'b1;
            st_q  <= E_GAP;
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        E_GAP: begin
          if (half_end) begin
            div_q <= '0;
            fin_q <= 1'b1;
            st_q  <= E_IDLE;
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end

  // R1: the serial clock rests low outside a frame
  a_r1_sck_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sck_o);

  // R2: data never moves while the serial clock is high
  a_r2_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    sck_o |-> $stable(mosi_o));

  // R10: chip select stays high for more than one clock between frames
  a_r10_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |=> cs_n_o);

endmodule

// File: rtl/fsq_step_ctrl.sv
module fsq_step_ctrl
  import fsq_pkg::*;
#(
  parameter int POLL_GAP   = 16,
  parameter int POLL_CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [7:0]            lat_i,
  input  logic [POLL_CNT_W-1:0] max_polls_i,
  input  logic                  fin_i,
  input  logic [7:0]            rx_byte_i,
  output logic                  go_o,
  output cmd_kind_e             kind_o,
  output logic [1:0]            step_o,
  output logic [7:0]            lat_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  error_o
);

  localparam int GAP_W = $clog2(POLL_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(POLL_GAP - 1);

  seq_state_e            st_q;
  cmd_kind_e             kind_q;
  logic [1:0]            step_q;
  logic [POLL_CNT_W-1:0] polls_q, maxp_q;
  logic [7:0]            lat_q;
  logic [GAP_W-1:0]      gap_q;
  logic                  done_q, err_q;
  logic                  wel_seen, polls_spent;

  assign wel_seen    = ((rx_byte_i & WEL_MASK) == WEL_MATCH);
  assign polls_spent = ({1'b0, polls_q} + 1'b1) >= {1'b0, maxp_q};

  assign go_o    = (st_q == S_ISSUE);
  assign kind_o  = kind_q;
  assign step_o  = step_q;
  assign lat_o   = lat_q;
  assign busy_o  = (st_q != S_IDLE);
  assign done_o  = done_q;
  assign error_o = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      kind_q  <= K_WREN;
      step_q  <= '0;
      polls_q <= '0;
      maxp_q  <= '0;
      lat_q   <= '0;
      gap_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (start_i) begin
            lat_q  <= lat_i;
            maxp_q <= max_polls_i;
            err_q  <= 1'b0;
            step_q <= '0;
            kind_q <= K_WREN;
            st_q   <= S_ISSUE;
          end
        end
        S_ISSUE: st_q <= S_WAIT;
        S_WAIT: begin
          if (fin_i) begin
            case (kind_q)
              K_WREN: begin
                kind_q  <= K_POLL;
                polls_q <= '0;
                st_q    <= S_ISSUE;
              end
              K_POLL: begin
                if (wel_seen) begin
                  kind_q <= K_WRITE;
                  st_q   <= S_ISSUE;
                end else if (polls_spent) begin
                  err_q <= 1'b1;
                  st_q  <= S_IDLE;
                end else begin
                  polls_q <= polls_q + 1'b1;
                  gap_q   <= '0;
                  st_q    <= S_GAP;
                end
              end
              default: begin
                if (step_q == LAST_STEP) begin
                  done_q <= 1'b1;
                  st_q   <= S_IDLE;
                end else begin
                  step_q <= step_q + 1'b1;
                  kind_q <= K_WREN;
                  st_q   <= S_ISSUE;
                end
              end
            endcase
          end
        end
        S_GAP: begin
          if (gap_q == GAP_LAST) st_q <= S_ISSUE;
          else                   gap_q <= gap_q + 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R7: completion is a single-cycle pulse
  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6: an aborted series leaves the block idle
  a_r6_error_idle: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> !busy_o);

  // R5: a repeated status read is launched only out of the pause
  a_r5_poll_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_ISSUE && kind_q == K_POLL && polls_q != '0) |-> $past(st_q) == S_GAP);

  // R9: the captured dummy value holds for the whole series
  a_r9_lat_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(lat_q));

  // R11: an accepted start clears the error flag
  a_r11_error_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !error_o);

endmodule

// File: rtl/octflash_modeswitch_seq.sv
module octflash_modeswitch_seq
  import fsq_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int POLL_GAP   = 16,
  parameter int POLL_CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [7:0]            dummy_cycles_i,
  input  logic [POLL_CNT_W-1:0] max_polls_i,
  input  logic                  miso_i,
  output logic                  cs_n_o,
  output logic                  sck_o,
  output logic                  mosi_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  error_o
);

  logic               go, fin;
  cmd_kind_e          kind;
  logic [1:0]         step;
  logic [7:0]         lat, rx_byte;
  logic [FRAME_W-1:0] tx_word;
  logic [CNT_W-1:0]   tx_bits, rx_bits;

  fsq_step_ctrl #(
    .POLL_GAP   (POLL_GAP),
    .POLL_CNT_W (POLL_CNT_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .lat_i       (dummy_cycles_i),
    .max_polls_i (max_polls_i),
    .fin_i       (fin),
    .rx_byte_i   (rx_byte),
    .go_o        (go),
    .kind_o      (kind),
    .step_o      (step),
    .lat_o       (lat),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .error_o     (error_o)
  );

  fsq_frame_build u_build (
    .kind_i    (kind),
    .step_i    (step),
    .lat_i     (lat),
    .tx_word_o (tx_word),
    .tx_bits_o (tx_bits),
    .rx_bits_o (rx_bits)
  );

  fsq_spi_engine #(
    .HALF_DIV (HALF_DIV)
  ) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (go),
    .tx_word_i (tx_word),
    .tx_bits_i (tx_bits),
    .rx_bits_i (rx_bits),
    .miso_i    (miso_i),
    .cs_n_o    (cs_n_o),
    .sck_o     (sck_o),
    .mosi_o    (mosi_o),
    .rx_byte_o (rx_byte),
    .fin_o     (fin)
  );

  // R7: completion is signalled with the bus released and the block idle
  a_r7_done_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cs_n_o && !busy_o));

endmodule

// File: tb/sim_octflash_modeswitch_seq.sv
module sim_octflash_modeswitch_seq;

  localparam int HALF_DIV = 2;
  localparam int POLL_GAP = 16;
  localparam int PCW      = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [7:0]     dummy = 8'd0;
  logic [PCW-1:0] maxp = 8'd1;
  logic           miso = 1'b0;
  logic           cs_n, sck, mosi, busy, done, err;

  octflash_modeswitch_seq #(
    .HALF_DIV (HALF_DIV), .POLL_GAP (POLL_GAP), .POLL_CNT_W (PCW)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .start_i (start), .dummy_cycles_i (dummy),
    .max_polls_i (maxp), .miso_i (miso), .cs_n_o (cs_n), .sck_o (sck),
    .mosi_o (mosi), .busy_o (busy), .done_o (done), .error_o (err)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // flash model
  logic [63:0] sh;
  int          nb;
  logic [7:0]  opc, stat, pass_pat, fail_pat;
  logic        wel = 1'b0;
  int          since = 0;
  int          dly = 0;
  int          fs;
  logic [63:0] f_val [0:63];
  int          f_nb [0:63];
  int          f_s [0:63];
  int          f_e [0:63];
  int          nf = 0;

  always @(negedge cs_n) begin
    sh = '0; nb = 0; opc = 8'h00; fs = cyc;
  end

  always @(posedge sck) begin
    if (!cs_n) begin
      sh = {sh[62:0], mosi};
      nb++;
      if (nb == 8) begin
        opc = sh[7:0];
        if (opc == 8'h05) begin
          stat = (wel && since >= dly) ? pass_pat : fail_pat;
          since++;
        end
      end
    end
  end

  always @(negedge sck) begin
    if (!cs_n && opc == 8'h05 && nb >= 8 && nb < 16) miso <= stat[15-nb];
  end

  always @(posedge cs_n) begin
    if (nf < 64) begin
      f_val[nf] = sh; f_nb[nf] = nb; f_s[nf] = fs; f_e[nf] = cyc;
    end
    nf++;
    if (nb == 8 && opc == 8'h06) begin wel = 1'b1; since = 0; end
    if (opc == 8'h81) wel = 1'b0;
  end

  int ndone = 0;
  int done_cyc = 0;
  always @(negedge clk) begin
    if (rst_n && done === 1'b1) begin ndone++; done_cyc = cyc; end
  end

  task automatic run_case(input int d, input int m, input logic [7:0] dv,
                          input bit pass_hi, input bit mid);
    logic [63:0] ev [0:63];
    int          en [0:63];
    int          exp_n;
    bit          ok;
    dly = d; maxp = PCW'(m); dummy = dv; wel = 1'b0;
    pass_pat = pass_hi ? 8'hFF : 8'h02;
    fail_pat = 8'hFD;
    @(negedge clk);
    nf = 0; ndone = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8 busy after accepted start", longint'(busy), 1);
    chk(err == 1'b0, "R11 error cleared by start", longint'(err), 0);
    if (mid) begin
      repeat (30) @(negedge clk);
      start = 1'b1; dummy = ~dv;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    repeat (10) @(negedge clk);

    ok = (d < m);
    exp_n = 0;
    if (ok) begin
      for (int s = 0; s < 3; s++) begin
        ev[exp_n] = {56'h0, 8'h06}; en[exp_n] = 8; exp_n++;
        for (int p = 0; p <= d; p++) begin
          ev[exp_n] = {48'h0, 8'h05, 8'h00}; en[exp_n] = 16; exp_n++;
        end
        if (s == 0)      begin ev[exp_n] = {24'h0, 8'h81, 24'h000001, dv};    en[exp_n] = 40; end
        else if (s == 1) begin ev[exp_n] = {24'h0, 8'h81, 24'h000005, 8'hFE}; en[exp_n] = 40; end
        else             begin ev[exp_n] = {16'h0, 8'h81, 32'h0, 8'hE7};     en[exp_n] = 48; end
        exp_n++;
      end
    end else begin
      ev[exp_n] = {56'h0, 8'h06}; en[exp_n] = 8; exp_n++;
      for (int p = 0; p < m; p++) begin
        ev[exp_n] = {48'h0, 8'h05, 8'h00}; en[exp_n] = 16; exp_n++;
      end
    end

    chk(nf == exp_n, "R10 R8 frame count", longint'(nf), longint'(exp_n));
    for (int k = 0; k < exp_n && k < nf; k++) begin
      if (en[k] >= 40)
        chk(f_nb[k] == en[k] && f_val[k] == ev[k], "R4 R9 register write frame",
            longint'(f_val[k]), longint'(ev[k]));
      else
        chk(f_nb[k] == en[k] && f_val[k] == ev[k], "R2 R3 enable or status frame",
            longint'(f_val[k]), longint'(ev[k]));
      if (k > 0 && en[k] == 16 && en[k-1] == 16)
        chk(f_s[k] - f_e[k-1] >= POLL_GAP, "R5 pause between status reads",
            longint'(f_s[k] - f_e[k-1]), POLL_GAP);
    end
    chk(ndone == (ok ? 1 : 0), "R7 R6 done pulse count", longint'(ndone), ok ? 1 : 0);
    if (ok && nf > 0)
      chk(done_cyc >= f_e[nf-1], "R7 done after final frame", longint'(done_cyc),
          longint'(f_e[nf-1]));
    chk(err == !ok, "R6 R11 error flag held", longint'(err), longint'(!ok));
    chk(busy == 1'b0 && cs_n == 1'b1 && sck == 1'b0, "R1 idle bus after series",
        longint'({busy, cs_n, sck}), 3'b010);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(cs_n == 1'b1 && sck == 1'b0 && busy == 1'b0 && done == 1'b0 && err == 1'b0,
        "R1 reset state", longint'({cs_n, sck, busy, done, err}), 5'b10000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int m = 1; m <= 4; m++)
      for (int d = 0; d <= 4; d++)
        run_case(d, m, 8'(5 + d * 4 + m), m[0], 1'b0);
    run_case(1, 3, 8'd11, 1'b0, 1'b1);
    run_case(3, 2, 8'd9, 1'b1, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule